// File: doc/BRIEF.md
# Converter Serial Result Port

This block sends the 16-bit result of the previous conversion out on one serial data line. It sits behind the conversion engine: the engine supplies a new result with a one-cycle valid strobe, and this block keeps that word until a host asks for it with the read/convert and chip-select lines. Every host-side line (read/convert, chip select, external data clock, tag) is treated as a level that is sampled on the system clock `clk`. The block finds edges by comparing each level with its value one cycle earlier.

A mode input selects between two ways of moving the data. With the mode input low, the block makes its own data clock: a convert command starts a burst of exactly one word's worth of pulses, and the data clock then rests low. With the mode input high, the host supplies the data clock. A trigger arms the port, the next host clock pulse is marked by a SYNC pulse, and the result follows MSB first. Any bits the host presents on the tag input come out on the data line one word length later, so several converters can share one line in a chain. A format input chooses plain offset binary or two's complement; the second is made by inverting the MSB. A result that arrives while a word is still being sent is held back and replaces the stored word only after that word has finished.

Top module: `adc_serial_port`

## Requirements
- R1: With `mode_ext_i` low, a convert command (`rc_i` high→low while `cs_n_i` is low) produces exactly 16 high pulses on `dclk_o`, each high for HALF_CYC clocks and preceded by HALF_CYC low clocks. After the last pulse, `dclk_o` stays low until the next command.
- R2: In internal mode the word goes out MSB first. Each bit is on `sdata_o` during the low phase before its pulse and stays unchanged through the whole high phase, so it can be taken on either edge of `dclk_o`.
- R3: In internal mode, once the burst is over, `sdata_o` holds the level `tag_i` had in the cycle the convert command was detected.
- R4: With `mode_ext_i` high, a rising `rc_i` while `cs_n_i` is low, or a falling `cs_n_i` while `rc_i` is high, arms the port. `sync_o` then goes high on the next rising `ext_dclk_i` and low on the following falling `ext_dclk_i`. `sync_o` never rises in internal mode.
- R5: In external mode the rising `ext_dclk_i` that raises `sync_o` puts the MSB on `sdata_o`, and each later rising edge moves to the next lower bit.
- R6: In external mode the `tag_i` level sampled at the n-th rising `ext_dclk_i` (counting the SYNC pulse as 0) is on `sdata_o` after rising edge n+16.
- R7: With `fmt_sb_i` high the word is sent unchanged (offset binary). With it low, bit 15 is inverted (two's complement). The format is taken when the word is loaded for sending.
- R8: A result strobed in with `result_valid_i` while a word is being sent does not change that word, and it is the word sent by the next transfer.
- R9: In internal mode, a falling `rc_i` while `cs_n_i` is high starts nothing: `dclk_o` stays low.
- R10: After reset, `dclk_o`, `sync_o` and `sdata_o` are low, and the stored result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| result_i | input | 16 | Latched conversion result, offset binary |
| result_valid_i | input | 1 | One-cycle strobe: `result_i` holds a new result |
| rc_i | input | 1 | Read/convert control level |
| cs_n_i | input | 1 | Chip select, active low |
| mode_ext_i | input | 1 | 1 = host supplies data clock, 0 = block makes it |
| fmt_sb_i | input | 1 | 1 = offset binary, 0 = two's complement |
| tag_i | input | 1 | Chain input bit |
| ext_dclk_i | input | 1 | Host data clock, used in external mode |
| sdata_o | output | 1 | Serial data |
| dclk_o | output | 1 | Generated data clock, internal mode |
| sync_o | output | 1 | Frame marker, external mode |

## Verification
The checker watches the cycle-level rules on every clock: the generated clock never makes more than a word's worth of pulses per command, the data bit does not move while the generated clock is high, SYNC rises only right after a host clock rise and never in internal mode, and the outputs are quiet after reset. Other behaviours only show up in the bench's directed and random transfers. These are the bit order, the two output codings, the tag showing up one word later in the chain, the idle level after a burst, the two external trigger forms, and a result that arrives during a transfer being deferred to the next one.

// File: rtl/adc_serial_port_pkg.sv
package adc_serial_port_pkg;

    localparam int unsigned WORD_W = 16;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        XS_IDLE  = 2'd0,
        XS_ARMED = 2'd1,
        XS_SYNC  = 2'd2,
        XS_SHIFT = 2'd3
    } ext_state_t;

    // Edge events found on the sampled host lines
    typedef struct packed {
        logic int_cmd;
        logic ext_trig;
        logic dclk_rise;
        logic dclk_fall;
    } host_evt_t;

    // Offset binary stays as is; two's complement flips the top bit
    function automatic word_t apply_format(word_t raw, logic straight);
        word_t w;
        w = raw;
        if (!straight) w[WORD_W-1] = ~w[WORD_W-1];
        return w;
    endfunction

endpackage

// File: rtl/sp_host_decode.sv
module sp_host_decode
    import adc_serial_port_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      rc_i,
    input  logic      cs_n_i,
    input  logic      mode_ext_i,
    input  logic      ext_dclk_i,
    output host_evt_t evt_o
);
    logic rc_q;
    logic cs_n_q;
    logic dclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rc_q   <= 1'b1;
            cs_n_q <= 1'b1;
            dclk_q <= 1'b0;
        end else begin
            rc_q   <= rc_i;
            cs_n_q <= cs_n_i;
            dclk_q <= ext_dclk_i;
        end
    end

    always_comb begin
        evt_o.int_cmd   = !mode_ext_i && rc_q && !rc_i && !cs_n_i;
        evt_o.ext_trig  = mode_ext_i &&
                          ((!rc_q && rc_i && !cs_n_i) ||
                           (cs_n_q && !cs_n_i && rc_i));
        evt_o.dclk_rise = mode_ext_i && ext_dclk_i && !dclk_q;
        evt_o.dclk_fall = mode_ext_i && !ext_dclk_i && dclk_q;
    end
endmodule

// File: rtl/sp_result_store.sv
module sp_result_store
    import adc_serial_port_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t result_i,
    input  logic  result_valid_i,
    input  logic  tx_busy_i,
    output word_t cur_o
);
    word_t cur_q;
    word_t pend_q;
    logic  pend_v_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q    <= '0;
            pend_q   <= '0;
            pend_v_q <= 1'b0;
        end else if (result_valid_i) begin
            if (tx_busy_i) begin
                pend_q   <= result_i;
                pend_v_q <= 1'b1;
            end else begin
                cur_q    <= result_i;
                pend_v_q <= 1'b0;
            end
        end else if (!tx_busy_i && pend_v_q) begin
            cur_q    <= pend_q;
            pend_v_q <= 1'b0;
        end
    end

    assign cur_o = cur_q;
endmodule

// File: rtl/sp_int_tx.sv
module sp_int_tx
    import adc_serial_port_pkg::*;
#(
    parameter int unsigned HALF_CYC = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  en_i,
    input  logic  start_i,
    input  word_t word_i,
    input  logic  tag_i,
    output logic  busy_o,
    output logic  dclk_o,
    output logic  sdata_o
);
    localparam int unsigned DIV_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam int unsigned CNT_W = $clog2(WORD_W);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_CYC - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

    logic             busy_q;
    logic             hi_q;
    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] pcnt_q;
    word_t            sr_q;
    logic             tag_hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q     <= 1'b0;
            hi_q       <= 1'b0;
            div_q      <= '0;
            pcnt_q     <= '0;
            sr_q       <= '0;
            tag_hold_q <= 1'b0;
        end else if (!en_i) begin
            busy_q <= 1'b0;
            hi_q   <= 1'b0;
            div_q  <= '0;
        end else if (!busy_q) begin
            if (start_i) begin
                busy_q     <= 1'b1;
                hi_q       <= 1'b0;
                div_q      <= '0;
                pcnt_q     <= '0;
                sr_q       <= word_i;
                tag_hold_q <= tag_i;
            end
        end else if (div_q == DIV_LAST) begin
            div_q <= '0;
            if (!hi_q) begin
                hi_q <= 1'b1;
            end else begin
                hi_q <= 1'b0;
                sr_q <= {sr_q[WORD_W-2:0], 1'b0};
                if (pcnt_q == CNT_LAST) busy_q <= 1'b0;
                else                    pcnt_q <= pcnt_q + 1'b1;
            end
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign busy_o  = busy_q;
    assign dclk_o  = hi_q;
    assign sdata_o = busy_q ? sr_q[WORD_W-1] : tag_hold_q;
endmodule

// File: rtl/sp_ext_tx.sv
module sp_ext_tx
    import adc_serial_port_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en_i,
    input  host_evt_t evt_i,
    input  word_t     word_i,
    input  logic      tag_i,
    output logic      busy_o,
    output logic      sync_o,
    output logic      sdata_o
);
    localparam int unsigned SH_W = $clog2(WORD_W + 1);
    localparam logic [SH_W-1:0] SH_FULL = SH_W'(WORD_W);

    ext_state_t      st_q;
    word_t           sr_q;
    logic            tag_st_q;
    logic [SH_W-1:0] shcnt_q;
    logic            sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= XS_IDLE;
            sr_q     <= '0;
            tag_st_q <= 1'b0;
            shcnt_q  <= '0;
            sync_q   <= 1'b0;
        end else if (!en_i) begin
            st_q    <= XS_IDLE;
            sync_q  <= 1'b0;
            shcnt_q <= '0;
        end else if (evt_i.ext_trig) begin
            st_q   <= XS_ARMED;
            sync_q <= 1'b0;
        end else begin
            case (st_q)
                XS_ARMED: if (evt_i.dclk_rise) begin
                    sr_q     <= word_i;
                    tag_st_q <= tag_i;
                    sync_q   <= 1'b1;
                    shcnt_q  <= '0;
                    st_q     <= XS_SYNC;
                end
                XS_SYNC: if (evt_i.dclk_fall) begin
                    sync_q <= 1'b0;
                    st_q   <= XS_SHIFT;
                end
                XS_SHIFT: if (evt_i.dclk_rise) begin
                    sr_q     <= {sr_q[WORD_W-2:0], tag_st_q};
                    tag_st_q <= tag_i;
                    if (shcnt_q != SH_FULL) shcnt_q <= shcnt_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy_o  = (st_q == XS_ARMED) || (st_q == XS_SYNC) ||
                     ((st_q == XS_SHIFT) && (shcnt_q != SH_FULL));
    assign sync_o  = sync_q;
    assign sdata_o = sr_q[WORD_W-1];
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
    import adc_serial_port_pkg::*;
#(
    parameter int unsigned HALF_CYC = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] result_i,
    input  logic        result_valid_i,
    input  logic        rc_i,
    input  logic        cs_n_i,
    input  logic        mode_ext_i,
    input  logic        fmt_sb_i,
    input  logic        tag_i,
    input  logic        ext_dclk_i,
    output logic        sdata_o,
    output logic        dclk_o,
    output logic        sync_o
);
    host_evt_t evt;
    word_t     cur_word;
    word_t     load_word;
    logic      int_busy;
    logic      ext_busy;
    logic      int_sdata;
    logic      ext_sdata;

    sp_host_decode u_dec (
        .clk        (clk),
        .rst        (rst),
        .rc_i       (rc_i),
        .cs_n_i     (cs_n_i),
        .mode_ext_i (mode_ext_i),
        .ext_dclk_i (ext_dclk_i),
        .evt_o      (evt)
    );

    sp_result_store u_store (
        .clk            (clk),
        .rst            (rst),
        .result_i       (result_i),
        .result_valid_i (result_valid_i),
        .tx_busy_i      (int_busy || ext_busy),
        .cur_o          (cur_word)
    );

    assign load_word = apply_format(cur_word, fmt_sb_i);

    sp_int_tx #(.HALF_CYC(HALF_CYC)) u_int (
        .clk     (clk),
        .rst     (rst),
        .en_i    (!mode_ext_i),
        .start_i (evt.int_cmd),
        .word_i  (load_word),
        .tag_i   (tag_i),
        .busy_o  (int_busy),
        .dclk_o  (dclk_o),
        .sdata_o (int_sdata)
    );

    sp_ext_tx u_ext (
        .clk     (clk),
        .rst     (rst),
        .en_i    (mode_ext_i),
        .evt_i   (evt),
        .word_i  (load_word),
        .tag_i   (tag_i),
        .busy_o  (ext_busy),
        .sync_o  (sync_o),
        .sdata_o (ext_sdata)
    );

    assign sdata_o = mode_ext_i ? ext_sdata : int_sdata;
endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk (
    input logic clk,
    input logic rst,
    input logic rc_i,
    input logic cs_n_i,
    input logic mode_ext_i,
    input logic ext_dclk_i,
    input logic sdata_o,
    input logic dclk_o,
    input logic sync_o
);
    logic       rc_d;
    logic       dclk_d;
    logic [5:0] rise_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            rc_d     <= 1'b1;
            dclk_d   <= 1'b0;
            rise_cnt <= '0;
        end else begin
            rc_d   <= rc_i;
            dclk_d <= dclk_o;
            if (!mode_ext_i && rc_d && !rc_i && !cs_n_i) rise_cnt <= '0;
            else if (dclk_o && !dclk_d && rise_cnt != 6'h3f) rise_cnt <= rise_cnt + 1'b1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!dclk_o && !sync_o && !sdata_o)); // R10

    AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (rst)
        rise_cnt <= 6'd16); // R1

    AST_BIT_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
        (!mode_ext_i && $past(!mode_ext_i) && dclk_o && $past(dclk_o))
        |-> $stable(sdata_o)); // R2

    AST_SYNC_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_o) |-> $past(ext_dclk_i)); // R4

    AST_NO_SYNC_INT: assert property (@(posedge clk) disable iff (rst)
        (!mode_ext_i && $past(!mode_ext_i)) |-> !sync_o); // R4
endmodule

bind adc_serial_port adc_serial_port_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .rc_i       (rc_i),
    .cs_n_i     (cs_n_i),
    .mode_ext_i (mode_ext_i),
    .ext_dclk_i (ext_dclk_i),
    .sdata_o    (sdata_o),
    .dclk_o     (dclk_o),
    .sync_o     (sync_o)
);

// File: tb/adc_serial_port_test.sv
`timescale 1ns/1ps
module adc_serial_port_test;
    localparam int HALF = 2;
    localparam int W = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] result_i;
    logic        result_valid_i;
    logic        rc_i;
    logic        cs_n_i;
    logic        mode_ext_i;
    logic        fmt_sb_i;
    logic        tag_i;
    logic        ext_dclk_i;
    logic        sdata_o;
    logic        dclk_o;
    logic        sync_o;

    int errors = 0;
    int checks = 0;
    logic [15:0] stored;

    always #2.5 clk = ~clk;

    adc_serial_port #(.HALF_CYC(HALF)) uut (
        .clk(clk), .rst(rst), .result_i(result_i), .result_valid_i(result_valid_i),
        .rc_i(rc_i), .cs_n_i(cs_n_i), .mode_ext_i(mode_ext_i), .fmt_sb_i(fmt_sb_i),
        .tag_i(tag_i), .ext_dclk_i(ext_dclk_i), .sdata_o(sdata_o), .dclk_o(dclk_o),
        .sync_o(sync_o)
    );

    function automatic logic [15:0] coded(logic [15:0] raw, logic sb);
        return sb ? raw : {~raw[15], raw[14:0]};
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic push(input logic [15:0] v);
        result_i = v; result_valid_i = 1'b1;
        tick(1);
        result_valid_i = 1'b0;
        stored = v;
    endtask

    // Internal-clock burst; optional mid-burst result push
    task automatic int_frame(input logic sb, input logic tg, input logic do_push,
                             input logic [15:0] pv);
        logic [15:0] exp_w;
        logic [15:0] got;
        int   rises;
        logic prev_d, prev_s, bit_v, hold_ok, setup_ok;
        exp_w = coded(stored, sb);
        got = '0; rises = 0; prev_d = 1'b0; prev_s = 1'b0; bit_v = 1'b0;
        hold_ok = 1'b1; setup_ok = 1'b1;
        fmt_sb_i = sb; cs_n_i = 1'b0; rc_i = 1'b1;
        tick(2);
        tag_i = tg; rc_i = 1'b0;
        for (int c = 0; c < W * 2 * HALF + 20; c++) begin
            tick(1);
            if (c == 3 * HALF) tag_i = ~tg;
            if (do_push && c == 10) begin
                result_i = pv; result_valid_i = 1'b1;
            end else begin
                result_valid_i = 1'b0;
            end
            if (dclk_o && !prev_d) begin
                if (rises < W) got[W-1-rises] = sdata_o;
                if (sdata_o !== prev_s) setup_ok = 1'b0;
                bit_v = sdata_o;
                rises++;
            end else if (dclk_o && prev_d) begin
                if (sdata_o !== bit_v) hold_ok = 1'b0;
            end
            prev_d = dclk_o; prev_s = sdata_o;
        end
        rc_i = 1'b1;
        if (do_push) stored = pv;
        chk(rises == W, "R1 pulse count", rises, W);
        chk(dclk_o == 1'b0, "R1 clock idles low", dclk_o, 0);
        chk(got == exp_w, "R2/R7 word", got, exp_w);
        chk(setup_ok && hold_ok, "R2 bit stable over pulse", {setup_ok, hold_ok}, 3);
        chk(sdata_o == tg, "R3 idle tag level", sdata_o, tg);
    endtask

    // External-clock transfer; use_cs selects the chip-select trigger form
    task automatic ext_frame(input logic sb, input logic use_cs);
        logic [15:0] exp_w;
        logic [15:0] got;
        logic [W+7:0] tags;
        logic [7:0]  tag_out;
        logic        sync_late;
        exp_w = coded(stored, sb);
        got = '0; tag_out = '0; sync_late = 1'b0;
        fmt_sb_i = sb; mode_ext_i = 1'b1; ext_dclk_i = 1'b0;
        if (use_cs) begin
            rc_i = 1'b1; cs_n_i = 1'b1; tick(2);
            cs_n_i = 1'b0;
        end else begin
            cs_n_i = 1'b0; rc_i = 1'b0; tick(2);
            rc_i = 1'b1;
        end
        tick(2);
        for (int k = 0; k < W + 8; k++) begin
            tags[k] = 1'($urandom);
            tag_i = tags[k];
            tick(3);
            if (k == 1) sync_late = sync_o;
            ext_dclk_i = 1'b1;
            tick(3);
            if (k == 0) chk(sync_o == 1'b1, "R4 sync on first clock", sync_o, 1);
            if (k < W) got[W-1-k] = sdata_o;
            else tag_out[k-W] = sdata_o;
            tick(1);
            ext_dclk_i = 1'b0;
        end
        chk(sync_late == 1'b0, "R4 sync ends on fall", sync_late, 0);
        chk(got == exp_w, "R5/R7 word", got, exp_w);
        chk(tag_out == tags[7:0], "R6 tag delayed by 16", tag_out, tags[7:0]);
        tick(4);
        mode_ext_i = 1'b0;
        tick(2);
    endtask

    initial begin
        #(150000 * 5);
        errors++; checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        rst = 1'b1; result_i = '0; result_valid_i = 1'b0; rc_i = 1'b1; cs_n_i = 1'b1;
        mode_ext_i = 1'b0; fmt_sb_i = 1'b1; tag_i = 1'b0; ext_dclk_i = 1'b0;
        stored = '0;
        tick(4);
        rst = 1'b0;
        tick(1);
        chk({dclk_o, sync_o, sdata_o} == 3'b000, "R10 reset outputs", {dclk_o, sync_o, sdata_o}, 0);
        // R10: stored word after reset is zero; straight format sends 0x0000
        int_frame(1'b1, 1'b1, 1'b0, '0);

        // R7 corners
        push(16'h0000); int_frame(1'b0, 1'b0, 1'b0, '0);
        push(16'hFFFF); int_frame(1'b0, 1'b1, 1'b0, '0);
        push(16'h8001); int_frame(1'b1, 1'b0, 1'b0, '0);

        // R9: falling rc with chip select high
        cs_n_i = 1'b1; rc_i = 1'b1; tick(2); rc_i = 1'b0;
        begin
            logic seen;
            seen = 1'b0;
            for (int c = 0; c < 60; c++) begin tick(1); if (dclk_o) seen = 1'b1; end
            chk(seen == 1'b0, "R9 deselected command ignored", seen, 0);
        end
        rc_i = 1'b1; tick(2);

        // R8: result arriving mid-burst is deferred
        push(16'h1234);
        begin
            logic [15:0] keep;
            keep = stored;
            int_frame(1'b1, 1'b0, 1'b1, 16'hBEEF);
            chk(stored == 16'hBEEF && keep == 16'h1234, "R8 setup", stored, 16'hBEEF);
        end
        int_frame(1'b1, 1'b1, 1'b0, '0);

        // External mode: both trigger forms
        push(16'hA5C3); ext_frame(1'b1, 1'b0);
        push(16'h3C5A); ext_frame(1'b0, 1'b1);

        // Random mix
        for (int n = 0; n < 8; n++) begin
            push(16'($urandom));
            if (n % 2 == 0) int_frame(1'($urandom), 1'($urandom), 1'b0, '0);
            else            ext_frame(1'($urandom), 1'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule